// File: doc/BRIEF.md
# Streaming LSTM Element-Wise Unit

This unit sits behind a matrix-vector engine that produces the gate pre-activations of an LSTM cell. The engine's weight rows are interleaved, so for every hidden index the four pre-activations arrive back to back as a four-beat group. The unit applies the gate activations as each beat arrives, reads and updates the cell state held for that hidden index, and emits the new hidden value and the new cell state. No gate vector is ever buffered; only one group is open at a time.

Both activations are piecewise-linear with unit-wide segments over [-8, +8], and every arithmetic result is saturated to 16 bits. A start flag on the first beat of a group makes the stored cell state read as zero, which opens a new sequence. A flush input abandons a half-delivered group, reports the loss, and leaves the stored state untouched.

Top module: `lstm_eltwise_unit`

## Requirements
- R1: All data are signed 16-bit, 8 fractional bits (1.0 = 256). A beat is accepted on a rising edge where `in_valid` is high and `flush` is low. Beats of a group come in the order input gate i, candidate g, forget gate f, output gate o, and idle cycles may fall between beats.
- R2: Sigmoid: for |x| >= 8.0 the magnitude result is 256. Otherwise, with s = floor(|x|/256) and r = |x| mod 256, the result is K[s] + floor((K[s+1]-K[s])*r/256), using knots K[0..8] = 128, 187, 225, 244, 251, 254, 255, 256, 256. For negative x the output is 256 minus that result.
- R3: Tanh uses the same rule with knots T[0..8] = 0, 195, 247, 255, 256, 256, 256, 256, 256, and for negative x the output is the negated result.
- R4: A product a*b is floor(a*b/256), clamped to [-32768, 32767]. The sum forming the new cell state is also clamped to that range.
- R5: On group completion, c_new = sigmoid(f)*c_old + sigmoid(i)*tanh(g), and h = sigmoid(o)*tanh(c_new). `out_valid` is high for one cycle, two rising edges after the edge that accepts the o beat, with `out_h`, `out_c` and `out_idx` (the index from the i beat).
- R6: The cell state is kept per hidden index. A later group for the same index uses the stored c_new as c_old, even when it follows with no idle cycle.
- R7: If `seq_start` is high with the i beat, c_old is taken as zero for that group.
- R8: A flush in a cycle where one to three beats of a group are accepted discards that group. `grp_dropped` is then high for exactly one cycle, after the next edge. No output appears for the group, and its index's stored state is unchanged. A beat presented together with flush is ignored. A flush with no open group raises nothing.
- R9: After a flush, the next accepted beat is treated as an i beat.
- R10: After reset, `out_valid` and `grp_dropped` are low and the next accepted beat is an i beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A gate value is presented |
| in_data | input | 16 | Gate pre-activation, Q8.8 |
| in_idx | input | HID_W | Hidden index, sampled with the i beat |
| seq_start | input | 1 | Zero the old cell state, sampled with the i beat |
| flush | input | 1 | Abandon any open group |
| out_valid | output | 1 | Result strobe |
| out_h | output | 16 | New hidden value, Q8.8 |
| out_c | output | 16 | New cell state, Q8.8 |
| out_idx | output | HID_W | Hidden index of the result |
| grp_dropped | output | 1 | One-cycle pulse when an open group is discarded |

## Verification
A slipped beat counter shows up in the first group after the fault: gates get swapped and `out_h`/`out_c` are wrong, or an output appears on the wrong cycle or not at all. A bad cell-state read or write stays hidden until the same index is used again. The back-to-back same-index groups, the flush-then-reuse sequence and the long saturation run are built to expose it at that next group. Activation faults are caught by inputs that land on knots, between knots, beyond the clamp and on both signs.

// File: rtl/lstm_ew_pkg.sv
// Package: shared fixed-point type, gate beat positions and saturating
// arithmetic for the LSTM element-wise unit.
// Assumes Q8.8 signed data; all helpers are pure functions.
package lstm_ew_pkg;

    localparam int DW   = 16;
    localparam int FRAC = 8;

    typedef logic signed [DW-1:0] fx_t;

    // Beat position within a four-value gate group (arrival order matters)
    typedef enum logic [1:0] {
        BEAT_I = 2'd0,
        BEAT_G = 2'd1,
        BEAT_F = 2'd2,
        BEAT_O = 2'd3
    } beat_t;

    // Clamp a 32-bit signed value into the 16-bit data range
    function automatic fx_t sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)
            return fx_t'(16'sh7fff);
        else if (v < -32'sd32768)
            return fx_t'(16'sh8000);
        else
            return fx_t'(v[DW-1:0]);
    endfunction

    // Q8.8 multiply: floor of the product scaled back, then saturated
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [31:0] p;
        p = a * b;
        return sat16(p >>> FRAC);
    endfunction

    // Q8.8 saturating add
    function automatic fx_t fx_add(input fx_t a, input fx_t b);
        logic signed [31:0] s;
        s = {{16{a[DW-1]}}, a} + {{16{b[DW-1]}}, b};
        return sat16(s);
    endfunction

endpackage

// File: rtl/lstm_pwl_act.sv
// Piecewise-linear activation, purely combinational.
// IS_TANH selects tanh (odd symmetry) or sigmoid (symmetry about 0.5).
// Works on |x| with unit-wide segments up to 8.0, clamps beyond.
// Assumes knot values are non-decreasing so the slope term is non-negative.
module lstm_pwl_act
    import lstm_ew_pkg::*;
#(
    parameter bit IS_TANH = 1'b0
) (
    input  fx_t x,
    output fx_t y
);

    localparam int KNOT_W   = FRAC + 1;          // knot range 0..256
    localparam int CLAMP_AT = 8 << FRAC;         // 8.0
    localparam int MAG_W    = DW + 1;

    // Knot lookup for the positive half
    function automatic logic [KNOT_W-1:0] knot(input logic [3:0] k);
        if (IS_TANH) begin
            case (k)
                4'd0:    return 9'd0;
                4'd1:    return 9'd195;
                4'd2:    return 9'd247;
                4'd3:    return 9'd255;
                default: return 9'd256;
            endcase
        end else begin
            case (k)
                4'd0:    return 9'd128;
                4'd1:    return 9'd187;
                4'd2:    return 9'd225;
                4'd3:    return 9'd244;
                4'd4:    return 9'd251;
                4'd5:    return 9'd254;
                4'd6:    return 9'd255;
                default: return 9'd256;
            endcase
        end
    endfunction

    logic signed [MAG_W-1:0] x_ext;
    logic [MAG_W-1:0]        mag;
    logic [3:0]              seg;
    logic [KNOT_W-1:0]       k_lo, k_hi, slope, interp, pos;
    logic [MAG_W-1:0]        prod;
    fx_t                     pos_fx;

    // Magnitude, segment select and linear interpolation
    always_comb begin
        x_ext  = {x[DW-1], x};
        mag    = x[DW-1] ? MAG_W'(-x_ext) : MAG_W'(x_ext);
        seg    = {1'b0, mag[FRAC+2:FRAC]};
        k_lo   = knot(seg);
        k_hi   = knot(seg + 4'd1);
        slope  = k_hi - k_lo;
        prod   = {{(MAG_W-KNOT_W){1'b0}}, slope} * {{(MAG_W-FRAC){1'b0}}, mag[FRAC-1:0]};
        interp = KNOT_W'(prod >> FRAC);
        pos    = (mag >= MAG_W'(CLAMP_AT)) ? knot(4'd8) : (k_lo + interp);
        pos_fx = fx_t'({{(DW-KNOT_W){1'b0}}, pos});
    end

    // Mirror the positive-half result for negative inputs
    generate
        if (IS_TANH) begin : g_tanh
            assign y = x[DW-1] ? -pos_fx : pos_fx;
            always_comb begin
                a_r3_tanh_range: assert (y >= -16'sd256 && y <= 16'sd256)
                    else $error("tanh output out of range");
            end
        end else begin : g_sig
            assign y = x[DW-1] ? (16'sd256 - pos_fx) : pos_fx;
            always_comb begin
                a_r2_sig_range: assert (y >= 16'sd0 && y <= 16'sd256)
                    else $error("sigmoid output out of range");
            end
        end
    endgenerate

endmodule

// File: rtl/lstm_cell_mem.sv
// Cell-state storage, one word per hidden index.
// Synchronous read (data one edge after rd_en) and synchronous write.
// Assumes the caller never reads and writes the same word on one edge.
module lstm_cell_mem
    import lstm_ew_pkg::*;
#(
    parameter int HID_W = 4
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [HID_W-1:0] rd_idx,
    output fx_t              rd_data,
    input  logic             wr_en,
    input  logic [HID_W-1:0] wr_idx,
    input  fx_t              wr_data
);

    localparam int DEPTH = 1 << HID_W;

    fx_t mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // Registered read port, holds its value between reads
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/lstm_group_seq.sv
// Beat sequencer: tracks the position inside the four-beat gate group,
// discards an open group on flush and pulses a drop indication.
// Assumes flush has priority over in_valid in the same cycle.
module lstm_group_seq
    import lstm_ew_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  flush,
    output logic  take,
    output beat_t beat,
    output logic  last,
    output logic  dropped
);

    beat_t pos_q;

    assign take = in_valid && !flush;
    assign beat = pos_q;
    assign last = take && (pos_q == BEAT_O);

    // Advance the beat position; reset it and flag a loss on flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= BEAT_I;
            dropped <= 1'b0;
        end else if (flush) begin
            pos_q   <= BEAT_I;
            dropped <= (pos_q != BEAT_I);
        end else begin
            dropped <= 1'b0;
            if (take)
                pos_q <= beat_t'(pos_q + 2'd1);
        end
    end

    // R8: an open group hit by flush is reported on the next cycle
    a_r8_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && pos_q != BEAT_I) |=> dropped)
        else $error("open group flushed without drop pulse");

    // R9: after a flush the sequencer waits for an i beat
    a_r9_flush_restart: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pos_q == BEAT_I))
        else $error("flush did not restart the group");

    // R8: no drop pulse without a flush the cycle before
    a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> $past(flush))
        else $error("drop pulse without flush");

endmodule

// File: rtl/lstm_eltwise_unit.sv
// Streaming LSTM element-wise unit (top).
// Consumes interleaved gate pre-activations (i, g, f, o per hidden index),
// forms c_new = s(f)*c_old + s(i)*tanh(g) and h = s(o)*tanh(c_new),
// keeping c per hidden index in a small RAM.
// Assumes the i beat carries the index and sequence-start flag; the cell
// read issued on the i beat is consumed on the f beat, and the write on
// the o beat lands before any later group's i beat can read it.
module lstm_eltwise_unit
    import lstm_ew_pkg::*;
#(
    parameter int HID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic [HID_W-1:0] in_idx,
    input  logic             seq_start,
    input  logic             flush,
    output logic             out_valid,
    output logic [DW-1:0]    out_h,
    output logic [DW-1:0]    out_c,
    output logic [HID_W-1:0] out_idx,
    output logic             grp_dropped
);

    logic  take, last;
    beat_t beat;

    fx_t x_in, sig_x, tnh_x, tnh_c;
    fx_t c_rd, c_old, c_new;
    logic rd_en, wr_en;

    logic [HID_W-1:0] idx_q, fin_idx;
    logic             start_q, fin_q;
    fx_t              sig_i_q, ig_q, fc_q, c_q, so_q;

    assign x_in = fx_t'(in_data);

    lstm_group_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .flush    (flush),
        .take     (take),
        .beat     (beat),
        .last     (last),
        .dropped  (grp_dropped)
    );

    lstm_pwl_act #(.IS_TANH(1'b0)) i_sig_in (.x(x_in), .y(sig_x));
    lstm_pwl_act #(.IS_TANH(1'b1)) i_tnh_in (.x(x_in), .y(tnh_x));
    lstm_pwl_act #(.IS_TANH(1'b1)) i_tnh_c  (.x(c_q),  .y(tnh_c));

    assign rd_en = take && (beat == BEAT_I);
    assign wr_en = last;
    assign c_old = start_q ? fx_t'(0) : c_rd;
    assign c_new = fx_add(fc_q, ig_q);

    lstm_cell_mem #(.HID_W(HID_W)) i_mem (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_idx  (in_idx),
        .rd_data (c_rd),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (c_new)
    );

    // Per-beat gate processing: capture, multiply and accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            start_q <= 1'b0;
            sig_i_q <= '0;
            ig_q    <= '0;
            fc_q    <= '0;
        end else if (take) begin
            case (beat)
                BEAT_I: begin
                    idx_q   <= in_idx;
                    start_q <= seq_start;
                    sig_i_q <= sig_x;
                end
                BEAT_G:  ig_q <= fx_mul(sig_i_q, tnh_x);
                BEAT_F:  fc_q <= fx_mul(sig_x, c_old);
                default: ;
            endcase
        end
    end

    // Completion stage: hold new cell state and output-gate activation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q   <= 1'b0;
            fin_idx <= '0;
            c_q     <= '0;
            so_q    <= '0;
        end else begin
            fin_q <= last;
            if (last) begin
                fin_idx <= idx_q;
                c_q     <= c_new;
                so_q    <= sig_x;
            end
        end
    end

    // Output stage: hidden value from output gate and tanh of cell state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_h     <= '0;
            out_c     <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= fin_q;
            if (fin_q) begin
                out_h   <= fx_mul(so_q, tnh_c);
                out_c   <= c_q;
                out_idx <= fin_idx;
            end
        end
    end

    // R5: every result follows a cell write two edges earlier
    a_r5_out_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wr_en, 2))
        else $error("output without completed group");

    // R5: a result strobe lasts one cycle per group
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid)
        else $error("result strobe longer than one cycle");

    // R7: a group opened with sequence start sees a zero old state
    a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (take && beat == BEAT_F && start_q) |=> (fc_q == 16'sd0))
        else $error("sequence start did not zero old state");

    // R6: the cell written is the one the group was opened for
    a_r6_write_index: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx == $past(idx_q, 2)))
        else $error("result index mismatch");

endmodule

// File: tb/test_lstm_eltwise_unit.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares on each result.
module test_lstm_eltwise_unit;

    localparam int HID_W = 4;
    localparam int DEPTH = 1 << HID_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [15:0]      in_data = '0;
    logic [HID_W-1:0] in_idx = '0;
    logic             seq_start = 1'b0;
    logic             flush = 1'b0;
    logic             out_valid;
    logic [15:0]      out_h, out_c;
    logic [HID_W-1:0] out_idx;
    logic             grp_dropped;

    always #2 clk = ~clk;   // 250 MHz

    lstm_eltwise_unit #(.HID_W(HID_W)) i_lstm_eltwise_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_idx(in_idx), .seq_start(seq_start), .flush(flush),
        .out_valid(out_valid), .out_h(out_h), .out_c(out_c),
        .out_idx(out_idx), .grp_dropped(grp_dropped)
    );

    typedef struct {
        int idx;
        int c;
        int h;
        int cyc;
    } exp_t;

    exp_t exp_q[$];
    int   ref_c[DEPTH];
    int   vectors = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Knots from R2 (sigmoid) and R3 (tanh)
    function automatic int ref_knot(bit th, int k);
        int s [9] = '{128, 187, 225, 244, 251, 254, 255, 256, 256};
        int t [9] = '{0, 195, 247, 255, 256, 256, 256, 256, 256};
        return th ? t[k] : s[k];
    endfunction

    function automatic int ref_act(bit th, int x);
        int m, p, s, r;
        m = (x < 0) ? -x : x;
        if (m >= 2048) p = 256;
        else begin
            s = m / 256;
            r = m % 256;
            p = ref_knot(th, s) + ((ref_knot(th, s + 1) - ref_knot(th, s)) * r) / 256;
        end
        if (x < 0) return th ? -p : 256 - p;
        return p;
    endfunction

    function automatic int ref_sat(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // R4: floor of product / 256, saturated
    function automatic int ref_mul(int a, int b);
        return ref_sat((a * b) >>> 8);
    endfunction

    function automatic int s16(int v);
        return int'($signed(16'(v)));
    endfunction

    task automatic drive(int d, int idx, bit st);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 16'(d);
        in_idx    = HID_W'(idx);
        seq_start = st;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            flush    = 1'b0;
        end
    endtask

    // Drive one complete group (R1 order) and queue its expected result
    task automatic send_group(int idx, bit st, int gi, int gg, int gf, int go, bit gaps);
        int c_old, c_new, hv, t3;
        exp_t e;
        c_old = st ? 0 : ref_c[idx];
        c_new = ref_sat(ref_mul(ref_act(0, gf), c_old) + ref_mul(ref_act(0, gi), ref_act(1, gg)));
        hv    = ref_mul(ref_act(0, go), ref_act(1, c_new));
        ref_c[idx] = c_new;
        drive(gi, idx, st);
        if (gaps) idle(1);
        drive(gg, 0, 0);
        if (gaps) idle(2);
        drive(gf, 0, 0);
        if (gaps) idle(1);
        drive(go, 0, 0);
        t3 = cyc;
        e.idx = idx; e.c = c_new; e.h = hv; e.cyc = t3 + 2;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each result with the head of the queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL R8: actual unexpected result idx %0d expected none", out_idx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R5 h", s16(int'(out_h)), e.h);
                chk("R5/R6 c", s16(int'(out_c)), e.c);
                chk("R5 idx", int'(out_idx), e.idx);
                chk("R5 latency", cyc, e.cyc);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 grp_dropped", int'(grp_dropped), 0);

        // R2/R3/R7: directed knots, between knots, clamps, both signs
        send_group(0, 1, 0, 256, 0, 0, 0);
        send_group(1, 1, -256, -512, 300, 1000, 1);
        send_group(2, 1, 2048, 2048, -2048, 2047, 0);
        send_group(3, 1, -32768, 32767, 777, -3000, 0);
        send_group(4, 1, 128, -100, 5000, -5000, 1);
        idle(4);

        // R6: back-to-back groups on one index, no idle cycles
        send_group(5, 1, 600, 400, 1500, 200, 0);
        send_group(5, 0, 900, -300, 1800, 700, 0);
        send_group(5, 0, -200, 1200, 2000, -50, 0);
        idle(3);

        // R1/R5/R6: random traffic over all indices with gaps
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < DEPTH; k++)
                send_group(k, s == 0, s16($urandom_range(0, 65535)) / 8,
                           s16($urandom_range(0, 65535)) / 8,
                           s16($urandom_range(0, 65535)) / 8,
                           s16($urandom_range(0, 65535)), k[0]);
        idle(4);

        // R8/R9: flush after two beats; beat with flush ignored
        drive(1000, 3, 0);
        drive(1000, 0, 0);
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_data = 16'd2000;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        chk("R8 drop pulse", int'(grp_dropped), 1);
        @(negedge clk);
        chk("R8 pulse one cycle", int'(grp_dropped), 0);
        // R8/R9: stored state for index 3 unchanged, fresh group aligned
        send_group(3, 0, 300, 500, 700, 900, 0);
        idle(3);

        // R8: flush with no open group
        @(negedge clk); flush = 1'b1; in_valid = 1'b0;
        @(negedge clk); flush = 1'b0;
        chk("R8 idle flush", int'(grp_dropped), 0);

        // R8: flush after three beats
        drive(100, 6, 1); drive(100, 0, 0); drive(100, 0, 0);
        @(negedge clk); flush = 1'b1; in_valid = 1'b0;
        @(negedge clk); flush = 1'b0;
        chk("R8 drop after three", int'(grp_dropped), 1);
        send_group(6, 0, -700, 300, 400, 100, 1);
        idle(3);

        // R4: cell state grows by 1.0 per step until it saturates
        send_group(7, 1, 2048, 2048, 2048, 2048, 0);
        for (int k = 0; k < 130; k++)
            send_group(7, 0, 2048, 2048, 2048, 2048, 0);
        // R4: negative saturation
        send_group(8, 1, 2048, -2048, 2048, 2048, 0);
        for (int k = 0; k < 130; k++)
            send_group(8, 0, 2048, -2048, 2048, -2048, 0);
        idle(6);

        // R5: every queued result was produced
        chk("R5 queue drained", exp_q.size(), 0);
        chk("R4 final sat", ref_c[7], 32767);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule